// File: doc/BRIEF.md
# I2C Interrupt Status Controller

This block keeps the interrupt state of an I2C master/slave peripheral. The protocol engine beside it raises one-cycle event pulses on a 16-bit event vector whose bit positions match the status word; each pulse latches a sticky status bit. A live bus-busy level is shown inside the status word but is never stored. A small register port reads the status word, reads and writes an interrupt enable mask, and reads a coded vector register. A single level-sensitive interrupt line is driven from the enabled status bits.

Software can service interrupts in two ways. It can read the status word and write ones back to clear the bits it has handled. It can also read the vector register, which returns a small code for the highest-priority enabled pending event and clears that event as a side effect of the read strobe.

Register addresses on `reg_addr_i`: 0 status, 1 enable, 2 vector, 3 reserved (reads 0). `reg_rdata_o` is combinational from the address alone; side effects occur only on `reg_wr_i` / `reg_rd_i` strobes, taking effect at the next rising clock edge.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset (asynchronous, active low) the status word, the enable mask and the vector code are 0 and `irq_o` is low.
- R2: A pulse on `ev_i` bit b sets status bit b at the next clock edge and the bit stays set after the pulse; sticky bits are 0 arbitration lost, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain (mask 0x6F1F).
- R3: A write to the status address clears each sticky bit written with 1 and leaves bits written with 0 unchanged.
- R4: When an event pulse and a clear (by status write or by vector read) hit the same bit in the same cycle, the bit stays set.
- R5: Status bit 12 reads the current `bus_busy_i` level; neither a status write nor `ev_i` bit 12 changes it.
- R6: The enable mask stores only bits 0 to 4, 13 and 14 (mask 0x601F) of a write to the enable address; other bits read 0.
- R7: `irq_o` is high exactly when some status bit is set whose enable bit is set; it follows the registered state with no extra delay.
- R8: The vector address reads code 0 for none, 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready, choosing the lowest-numbered status bit among bits 0 to 4 that is both pending and enabled.
- R9: A read strobe at the vector address clears the status bit matching the code shown at that edge; other bits are untouched, and a read of code 0 clears nothing.
- R10: Event bits 5, 6, 7 and 15 of `ev_i` have no effect; those status bits read 0.
- R11: Read strobes at the status and enable addresses change no state, and writes to the vector address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 16 | One-cycle event pulses, aligned to status bit positions |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_addr_i | input | 2 | Register address (0 status, 1 enable, 2 vector) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect on vector read) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench aims at collisions: an event landing in the same cycle as a write-one-to-clear or a vector read, where a design that let the clear win would silently drop an interrupt. It checks that the vector skips pending but disabled sources and walks the priority order as reads clear bits one by one, since a wrong encoder would report or clear the wrong source. It also confirms that bus busy cannot be latched or cleared, that unmapped event bits and enable bits stay zero, and that a vector read of code 0 or a write to the vector address leaves the status untouched.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int DATA_W  = 16;
  localparam int VEC_SRC = 5;
  localparam int VEC_W   = $clog2(VEC_SRC + 1);
  localparam int BB_BIT  = 12;

  localparam logic [DATA_W-1:0] STICKY_MASK = 16'h6F1F;
  localparam logic [DATA_W-1:0] EN_MASK     = 16'h601F;

  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_VEC  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2c_irq_stat.sv
module i2c_irq_stat #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic unused_bits;
  assign unused_bits = ^{set_i & ~MASK, clr_i & ~MASK};

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_sticky
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= 1'b0;
        else if (set_i[b])  q <= 1'b1;   // set beats clear
        else if (clr_i[b])  q <= 1'b0;
      end
      assign stat_o[b] = q;
    end else begin : g_tie
      assign stat_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec #(
  parameter int SRC = 5,
  localparam int CW = $clog2(SRC + 1)
) (
  input  logic [SRC-1:0] pend_i,
  output logic [CW-1:0]  code_o,
  output logic [SRC-1:0] sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = CW'(i + 1);
        sel_o  = SRC'(1) << i;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int CW  = VEC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] stat_i,
  input  logic         bus_busy_i,
  input  logic [CW-1:0] code_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] stat_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= '0;
    else if (wr_i && addr_i == ADDR_EN) en_q <= wdata_i & EN_MASK;
  end
  assign en_o = en_q;

  always_comb begin
    stat_view         = stat_i;
    stat_view[BB_BIT] = bus_busy_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT: rdata_o = stat_view;
      ADDR_EN:   rdata_o = en_q;
      ADDR_VEC:  rdata_o = {{(W-CW){1'b0}}, code_i};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ev_i,
  input  logic              bus_busy_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0]  stat_q;
  logic [DATA_W-1:0]  en_q;
  logic [DATA_W-1:0]  clr;
  logic [VEC_SRC-1:0] vec_sel;
  logic [VEC_W-1:0]   vec_code;
  logic               w1c_hit;
  logic               vrd_hit;

  assign w1c_hit = reg_wr_i && reg_addr_i == ADDR_STAT;
  assign vrd_hit = reg_rd_i && reg_addr_i == ADDR_VEC;

  always_comb begin
    clr = w1c_hit ? reg_wdata_i : '0;
    if (vrd_hit) clr[VEC_SRC-1:0] = clr[VEC_SRC-1:0] | vec_sel;
  end

  i2c_irq_stat #(.W(DATA_W), .MASK(STICKY_MASK)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_i),
    .clr_i  (clr),
    .stat_o (stat_q)
  );

  i2c_irq_vec #(.SRC(VEC_SRC)) u_vec (
    .pend_i (stat_q[VEC_SRC-1:0] & en_q[VEC_SRC-1:0]),
    .code_o (vec_code),
    .sel_o  (vec_sel)
  );

  i2c_irq_regif #(.W(DATA_W), .CW(VEC_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .stat_i     (stat_q),
    .bus_busy_i (bus_busy_i),
    .code_i     (vec_code),
    .en_o       (en_q),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_o = |(stat_q & en_q);
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] ev_i,
  input logic [1:0]        reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic [VEC_W-1:0]  vec_code
);
  logic               w1c;
  logic               vrd;
  logic [VEC_SRC-1:0] vsel;
  logic [DATA_W-1:0]  ev_s;

  assign w1c  = reg_wr_i && reg_addr_i == ADDR_STAT;
  assign vrd  = reg_rd_i && reg_addr_i == ADDR_VEC;
  assign vsel = (vec_code == '0) ? '0 : VEC_SRC'(1) << (vec_code - VEC_W'(1));
  assign ev_s = ev_i & STICKY_MASK;

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_s != '0) |=> ((stat_q & $past(ev_s)) == $past(ev_s))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c |=> ((stat_q & $past(reg_wdata_i & ~ev_i)) == '0)); // R3

  AST_STAT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!w1c && !vrd && ev_s == '0) |=> $stable(stat_q)); // R11

  AST_VEC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd && (vsel & ~ev_i[VEC_SRC-1:0]) != '0)
      |=> ((stat_q[VEC_SRC-1:0] & $past(vsel & ~ev_i[VEC_SRC-1:0])) == '0)); // R9

  AST_NO_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q == '0 || en_q == '0) |-> !irq_o); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~STICKY_MASK) == '0); // R10

  AST_EN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~EN_MASK) == '0); // R6

  AST_VEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vsel) && vec_code <= VEC_W'(VEC_SRC)); // R8
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_i        (ev_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .vec_code    (vec_code)
);

// File: tb/sim_i2c_irq_ctrl.sv
module sim_i2c_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ev_i = '0;
  logic        bus_busy_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  i2c_irq_ctrl u0 (.*);

  localparam logic [1:0] A_ST = 2'd0, A_EN = 2'd1, A_VC = 2'd2;

  typedef struct packed {
    logic [15:0] ev;
    logic        bb;
    logic        wr;
    logic [1:0]  waddr;
    logic [15:0] wdata;
    logic [1:0]  caddr;
    logic [15:0] exp;
    logic        eirq;
  } step_t;

  localparam int NSTEP = 14;
  localparam step_t TBL [NSTEP] = '{
    '{16'h0000, 1'b0, 1'b1, A_EN, 16'hFFFF, A_EN, 16'h601F, 1'b0}, // R6
    '{16'h0001, 1'b0, 1'b0, A_ST, 16'h0000, A_ST, 16'h0001, 1'b1}, // R2 R7
    '{16'h6F1E, 1'b0, 1'b0, A_ST, 16'h0000, A_ST, 16'h6F1F, 1'b1}, // R2
    '{16'h90E0, 1'b0, 1'b0, A_ST, 16'h0000, A_ST, 16'h6F1F, 1'b1}, // R10 R5
    '{16'h0000, 1'b0, 1'b1, A_ST, 16'h0000, A_ST, 16'h6F1F, 1'b1}, // R3 zero write
    '{16'h0000, 1'b0, 1'b1, A_ST, 16'h0F00, A_ST, 16'h601F, 1'b1}, // R3
    '{16'h0002, 1'b0, 1'b1, A_ST, 16'h0003, A_ST, 16'h601E, 1'b1}, // R4
    '{16'h0000, 1'b1, 1'b1, A_ST, 16'h1000, A_ST, 16'h701E, 1'b1}, // R5
    '{16'h0000, 1'b0, 1'b1, A_ST, 16'h601E, A_ST, 16'h0000, 1'b0}, // R3 R7
    '{16'h0100, 1'b0, 1'b0, A_ST, 16'h0000, A_ST, 16'h0100, 1'b0}, // R7 not enabled
    '{16'h0008, 1'b0, 1'b1, A_EN, 16'h0000, A_ST, 16'h0108, 1'b0}, // R7 mask off
    '{16'h0000, 1'b0, 1'b1, A_EN, 16'h0008, A_VC, 16'h0004, 1'b1}, // R8
    '{16'h0000, 1'b0, 1'b1, A_VC, 16'hFFFF, A_ST, 16'h0108, 1'b1}, // R11
    '{16'h0014, 1'b0, 1'b1, A_EN, 16'h001F, A_VC, 16'h0003, 1'b1}  // R8
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_at(input logic [1:0] a, input string req, input logic [15:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic cyc(input logic [15:0] ev, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    ev_i = ev; reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    ev_i = '0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk_i);
    rd_at(A_ST, "R1 status", 16'h0000);
    rd_at(A_EN, "R1 enable", 16'h0000);
    rd_at(A_VC, "R1 vector", 16'h0000);
    chk("R1 irq", {15'b0, irq_o}, 16'h0000);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk_i);
      ev_i = TBL[i].ev; bus_busy_i = TBL[i].bb; reg_wr_i = TBL[i].wr;
      reg_addr_i = TBL[i].waddr; reg_wdata_i = TBL[i].wdata;
      @(negedge clk_i);
      ev_i = '0; reg_wr_i = 1'b0; reg_addr_i = TBL[i].caddr;
      #1;
      chk($sformatf("R2-table step %0d data", i), reg_rdata_o, TBL[i].exp);
      chk($sformatf("R7 step %0d irq", i), {15'b0, irq_o}, {15'b0, TBL[i].eirq});
    end

    // R9: vector reads walk the priority order, clearing one source each
    cyc('0, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_ST, "R9 clear code 3", 16'h0118);
    rd_at(A_VC, "R8 next code 4", 16'h0004);
    cyc('0, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_VC, "R8 next code 5", 16'h0005);
    cyc('0, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_ST, "R9 clear code 5", 16'h0100);
    rd_at(A_VC, "R9 code none", 16'h0000);
    chk("R7 irq after drain", {15'b0, irq_o}, 16'h0000);
    cyc('0, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_ST, "R9 code 0 read clears nothing", 16'h0100);

    // R4: event coincides with vector read of the same source
    cyc(16'h0001, 1'b0, 1'b0, A_ST, '0);
    rd_at(A_VC, "R8 code 1", 16'h0001);
    cyc(16'h0001, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_ST, "R4 event beats vector clear", 16'h0101);
    cyc('0, 1'b0, 1'b1, A_VC, '0);
    rd_at(A_ST, "R9 clear code 1", 16'h0100);

    // R11: read strobes on status and enable have no side effect
    cyc(16'h0004, 1'b0, 1'b0, A_ST, '0);
    cyc('0, 1'b0, 1'b1, A_ST, '0);
    cyc('0, 1'b0, 1'b1, A_EN, '0);
    rd_at(A_ST, "R11 status read no effect", 16'h0104);
    rd_at(A_EN, "R11 enable read no effect", 16'h001F);

    // R8: disabled source skipped by the encoder
    cyc(16'h0003, 1'b1, 1'b0, A_EN, 16'h0002);
    rd_at(A_VC, "R8 disabled skipped", 16'h0002);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    reg_addr_i = A_ST; #1 chk("R1 mid status", reg_rdata_o, 16'h0000);
    reg_addr_i = A_EN; #1 chk("R1 mid enable", reg_rdata_o, 16'h0000);
    reg_addr_i = A_VC; #1 chk("R1 mid vector", reg_rdata_o, 16'h0000);
    chk("R1 mid irq", {15'b0, irq_o}, 16'h0000);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule